// File: doc/BRIEF.md
# Power Monitor I2C Command and Readback Slave

This block is the serial-bus slave of a power monitor. A bus master writes a command byte that selects which measurement channels (supply voltage, load current) are converted, and whether each conversion runs continuously or only once. The master can also select a voltage range and ask that reads return a status byte instead of measurement data. Three extended configuration registers (alert enable, alert threshold and control) are written through a pointer byte followed by a data byte.

Conversions are requested from an external converter through level request outputs. A single-cycle done input returns 12-bit voltage and current samples. Reads return these samples packed into two or three bytes, with the layout set by the channels the last command selected. While a one-shot conversion is still outstanding, a read is refused at the address phase.

SCL and SDA are sampled on the system clock through synchronizers, and START and STOP conditions are detected from the sampled lines. SDA is driven open-drain through an output-enable that pulls the line low. The block never stretches the clock and uses 7-bit addressing only.

Top module: `pmon_i2c_slave`

## Requirements
- R1: The slave answers only to the 7-bit address {1,1,1,addr_strap[1],addr_strap[0],1,0}. Its 8-bit write forms are E4, EC, F4 and FC for straps 00, 01, 10 and 11. Any other address is not acknowledged and changes no state.
- R2: A written byte with bit 7 = 0 is a command. Bit 0 selects continuous voltage conversion, bit 1 one-shot voltage, bit 2 continuous current, bit 3 one-shot current, bit 4 drives vrange_o and bit 6 selects status reads. conv_req_v is high while continuous or one-shot voltage conversion is wanted, and conv_req_i does the same for current.
- R3: A written byte with bit 7 = 1 arms a register pointer taken from its bits [1:0]: 01 alert enable, 10 alert threshold, 11 control. The next byte written in the same transaction is stored in that register and is not decoded as a command, so vrange_o is unchanged.
- R4: A one-shot request stays pending until conv_done and then clears itself, dropping its request output. A read addressed to the slave while any one-shot is pending is not acknowledged at the address phase.
- R5: Writing a command clears the stored results. A read in continuous mode before the first conv_done is acknowledged and returns zero bytes.
- R6: With both channels selected, a read returns V[11:4], then I[11:4], then {V[3:0], I[3:0]}.
- R7: With one channel selected, a read returns D[11:4], then {D[3:0], 4'h0}. Bytes requested beyond the payload read as 8'h00.
- R8: With the status-read bit set, the first read byte is status_in.
- R9: An address-only write followed by STOP (quick command) is acknowledged and changes no register or request output.
- R10: A master NACK after a read byte ends the read. The slave releases SDA and drives nothing until the next START.
- R11: A repeated START restarts the read payload at its first byte.
- R12: After reset SDA is released, both request outputs are low, vrange_o is low and all three extended registers read 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strap | input | 2 | Selects the two middle address bits |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls SDA low |
| conv_done | input | 1 | One-cycle pulse: samples below are valid |
| volt_data | input | 12 | Voltage sample |
| curr_data | input | 12 | Current sample |
| status_in | input | 8 | Status byte returned on status reads |
| conv_req_v | output | 1 | Voltage conversion wanted |
| conv_req_i | output | 1 | Current conversion wanted |
| vrange_o | output | 1 | Voltage range selection from the command |
| alert_en_o | output | 8 | Alert enable register |
| alert_thr_o | output | 8 | Alert threshold register |
| ctrl_o | output | 8 | Control register |

## Verification
The bench builds the block with its defaults: 12-bit samples and a two-stage line synchronizer. At a 16-cycle SCL high time and an 8-cycle quarter low time, the synchronizer latency falls well inside each bus phase. The strap is moved between two settings so that both a matching and a non-matching address reach the decoder. Channel mixes of voltage only, current only, both, and status cover every payload length, including reads that run past the payload.

// File: rtl/pmon_i2c_pkg.sv
package pmon_i2c_pkg;

    localparam int SAMPLE_W = 12;
    localparam int NIB_W    = SAMPLE_W - 8;

    localparam logic [2:0] ADDR_HI = 3'b111;
    localparam logic [1:0] ADDR_LO = 2'b10;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_ADDR,
        BS_AACK,
        BS_WDATA,
        BS_WACK,
        BS_RDATA,
        BS_RACK
    } bus_state_e;

    typedef enum logic [1:0] {
        XR_NONE  = 2'b00,
        XR_ALEN  = 2'b01,
        XR_THR   = 2'b10,
        XR_CTRL  = 2'b11
    } xreg_sel_e;

    typedef struct packed {
        logic stat_rd;
        logic vrange;
        logic i_once;
        logic i_cont;
        logic v_once;
        logic v_cont;
    } cmd_fields_t;

    function automatic cmd_fields_t decode_cmd(input logic [7:0] b);
        cmd_fields_t c;
        c.v_cont  = b[0];
        c.v_once  = b[1];
        c.i_cont  = b[2];
        c.i_once  = b[3];
        c.vrange  = b[4];
        c.stat_rd = b[6];
        return c;
    endfunction

    function automatic logic [6:0] slave_addr(input logic [1:0] strap);
        return {ADDR_HI, strap, ADDR_LO};
    endfunction

    function automatic logic [7:0] pick_byte(
        input logic                sel_v,
        input logic                sel_i,
        input logic                sel_st,
        input logic [7:0]          status,
        input logic [SAMPLE_W-1:0] v,
        input logic [SAMPLE_W-1:0] i,
        input logic [1:0]          idx
    );
        logic [7:0] r;
        r = 8'h00;
        if (sel_st) begin
            if (idx == 2'd0) r = status;
        end else if (sel_v && sel_i) begin
            case (idx)
                2'd0:    r = v[SAMPLE_W-1:NIB_W];
                2'd1:    r = i[SAMPLE_W-1:NIB_W];
                2'd2:    r = {v[NIB_W-1:0], i[NIB_W-1:0]};
                default: r = 8'h00;
            endcase
        end else if (sel_v) begin
            if (idx == 2'd0)      r = v[SAMPLE_W-1:NIB_W];
            else if (idx == 2'd1) r = {v[NIB_W-1:0], {NIB_W{1'b0}}};
        end else if (sel_i) begin
            if (idx == 2'd0)      r = i[SAMPLE_W-1:NIB_W];
            else if (idx == 2'd1) r = {i[NIB_W-1:0], {NIB_W{1'b0}}};
        end
        return r;
    endfunction

endpackage

// File: rtl/pmon_line_sync.sv
module pmon_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/pmon_cmd_regs.sv
module pmon_cmd_regs
    import pmon_i2c_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                txn_start,
    input  logic                wr_stb,
    input  logic [7:0]          wr_byte,
    input  logic                conv_done,
    input  logic [SAMPLE_W-1:0] volt_data,
    input  logic [SAMPLE_W-1:0] curr_data,
    output logic                conv_req_v,
    output logic                conv_req_i,
    output logic                busy,
    output logic                sel_v,
    output logic                sel_i,
    output logic                sel_st,
    output logic                vrange_o,
    output logic [7:0]          alert_en_o,
    output logic [7:0]          alert_thr_o,
    output logic [7:0]          ctrl_o,
    output logic [SAMPLE_W-1:0] v_res,
    output logic [SAMPLE_W-1:0] i_res
);
    cmd_fields_t cf;
    logic        v_cont, i_cont, v_pend, i_pend;
    logic        ext_armed;
    xreg_sel_e   ext_sel;

    assign cf = decode_cmd(wr_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            v_cont <= 1'b0; i_cont <= 1'b0;
            v_pend <= 1'b0; i_pend <= 1'b0;
            sel_v  <= 1'b0; sel_i  <= 1'b0; sel_st <= 1'b0;
            vrange_o    <= 1'b0;
            alert_en_o  <= '0;
            alert_thr_o <= '0;
            ctrl_o      <= '0;
            v_res <= '0; i_res <= '0;
            ext_armed <= 1'b0;
            ext_sel   <= XR_NONE;
        end else begin
            if (txn_start) ext_armed <= 1'b0;
            if (conv_done) begin
                if (conv_req_v) begin
                    v_res  <= volt_data;
                    v_pend <= 1'b0;
                end
                if (conv_req_i) begin
                    i_res  <= curr_data;
                    i_pend <= 1'b0;
                end
            end
            if (wr_stb) begin
                if (ext_armed) begin
                    ext_armed <= 1'b0;
                    case (ext_sel)
                        XR_ALEN: alert_en_o  <= wr_byte;
                        XR_THR:  alert_thr_o <= wr_byte;
                        XR_CTRL: ctrl_o      <= wr_byte;
                        default: ;
                    endcase
                end else if (wr_byte[7]) begin
                    ext_armed <= 1'b1;
                    ext_sel   <= xreg_sel_e'(wr_byte[1:0]);
                end else begin
                    v_cont   <= cf.v_cont;
                    i_cont   <= cf.i_cont;
                    v_pend   <= cf.v_once;
                    i_pend   <= cf.i_once;
                    sel_v    <= cf.v_cont | cf.v_once;
                    sel_i    <= cf.i_cont | cf.i_once;
                    sel_st   <= cf.stat_rd;
                    vrange_o <= cf.vrange;
                    v_res    <= '0;
                    i_res    <= '0;
                end
            end
        end
    end

    assign conv_req_v = v_cont | v_pend;
    assign conv_req_i = i_cont | i_pend;
    assign busy       = v_pend | i_pend;

    // R3: a data byte aimed at an extended register leaves command state alone
    a_r3_ext_keeps_range: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && ext_armed) |=> ($stable(vrange_o) && $stable(sel_st)));

    // R4: a done pulse with no competing write clears every pending one-shot
    a_r4_done_clears_pending: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !wr_stb) |=> !busy);

    // R5: a command always leaves the result registers empty
    a_r5_cmd_zeroes_results: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !ext_armed && !wr_byte[7]) |=> (v_res == '0 && i_res == '0));

endmodule

// File: rtl/pmon_i2c_slave.sv
module pmon_i2c_slave
    import pmon_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          addr_strap,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe,
    input  logic                conv_done,
    input  logic [SAMPLE_W-1:0] volt_data,
    input  logic [SAMPLE_W-1:0] curr_data,
    input  logic [7:0]          status_in,
    output logic                conv_req_v,
    output logic                conv_req_i,
    output logic                vrange_o,
    output logic [7:0]          alert_en_o,
    output logic [7:0]          alert_thr_o,
    output logic [7:0]          ctrl_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    pmon_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    bus_state_e          state;
    logic [7:0]          shreg;
    logic [3:0]          bitcnt;
    logic                sda_drive;
    logic [1:0]          byte_idx;
    logic                rw_q;
    logic                wr_stb;
    logic [7:0]          wr_byte;
    logic                busy, sel_v, sel_i, sel_st;
    logic [SAMPLE_W-1:0] v_res, i_res;
    logic [7:0]          rd_byte;
    logic [1:0]          idx_next;

    pmon_cmd_regs u_regs (
        .clk(clk), .rst(rst), .txn_start(start_det),
        .wr_stb(wr_stb), .wr_byte(wr_byte),
        .conv_done(conv_done), .volt_data(volt_data), .curr_data(curr_data),
        .conv_req_v(conv_req_v), .conv_req_i(conv_req_i), .busy(busy),
        .sel_v(sel_v), .sel_i(sel_i), .sel_st(sel_st),
        .vrange_o(vrange_o), .alert_en_o(alert_en_o),
        .alert_thr_o(alert_thr_o), .ctrl_o(ctrl_o),
        .v_res(v_res), .i_res(i_res)
    );

    assign rd_byte  = pick_byte(sel_v, sel_i, sel_st, status_in, v_res, i_res, byte_idx);
    assign idx_next = (byte_idx == 2'd3) ? byte_idx : byte_idx + 2'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= BS_IDLE;
            shreg     <= '0;
            bitcnt    <= '0;
            sda_drive <= 1'b0;
            byte_idx  <= '0;
            rw_q      <= 1'b0;
            wr_stb    <= 1'b0;
            wr_byte   <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_det) begin
                state     <= BS_ADDR;
                bitcnt    <= '0;
                sda_drive <= 1'b0;
                byte_idx  <= '0;
            end else if (stop_det) begin
                state     <= BS_IDLE;
                sda_drive <= 1'b0;
            end else begin
                case (state)
                    BS_ADDR, BS_WDATA: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            if (state == BS_WDATA) begin
                                wr_stb    <= 1'b1;
                                wr_byte   <= shreg;
                                sda_drive <= 1'b1;
                                state     <= BS_WACK;
                            end else if (shreg[7:1] == slave_addr(addr_strap)
                                         && !(shreg[0] && busy)) begin
                                rw_q      <= shreg[0];
                                sda_drive <= 1'b1;
                                state     <= BS_AACK;
                            end else begin
                                state <= BS_IDLE;
                            end
                        end
                    end
                    BS_WACK: begin
                        if (scl_fall) begin
                            sda_drive <= 1'b0;
                            bitcnt    <= '0;
                            state     <= BS_WDATA;
                        end
                    end
                    BS_AACK, BS_RACK: begin
                        if (state == BS_RACK && scl_rise && sda_s) begin
                            state <= BS_IDLE;
                        end else if (scl_fall) begin
                            if (state == BS_AACK && !rw_q) begin
                                sda_drive <= 1'b0;
                                bitcnt    <= '0;
                                state     <= BS_WDATA;
                            end else begin
                                shreg     <= rd_byte;
                                sda_drive <= ~rd_byte[7];
                                bitcnt    <= 4'd1;
                                byte_idx  <= idx_next;
                                state     <= BS_RDATA;
                            end
                        end
                    end
                    BS_RDATA: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_drive <= 1'b0;
                                state     <= BS_RACK;
                            end else begin
                                shreg     <= {shreg[6:0], 1'b0};
                                sda_drive <= ~shreg[6];
                                bitcnt    <= bitcnt + 4'd1;
                            end
                        end
                    end
                    default: sda_drive <= 1'b0;
                endcase
            end
        end
    end

    assign sda_oe = sda_drive;

    // R10: an idle slave never pulls the line
    a_r10_idle_released: assert property (@(posedge clk) disable iff (rst)
        (state == BS_IDLE) |-> !sda_drive);

    // R10: SDA from the slave only moves while the bus clock is low
    a_r10_sda_steady_high: assert property (@(posedge clk) disable iff (rst)
        (scl_s && $past(scl_s)) |-> $stable(sda_drive));

    // R4: a read is never acknowledged while a one-shot is pending
    a_r4_no_ack_busy_read: assert property (@(posedge clk) disable iff (rst)
        (state == BS_AACK && rw_q) |-> !busy);

endmodule

// File: tb/pmon_i2c_slave_test.sv
module pmon_i2c_slave_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [1:0]  addr_strap = 2'b10;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        sda_oe;
    logic        conv_done = 1'b0;
    logic [11:0] volt_data = '0, curr_data = '0;
    logic [7:0]  status_in = 8'h96;
    logic        conv_req_v, conv_req_i, vrange_o;
    logic [7:0]  alert_en_o, alert_thr_o, ctrl_o;
    logic        sda_line;

    assign sda_line = sda_m & ~sda_oe;

    pmon_i2c_slave uut (
        .clk(clk), .rst(rst), .addr_strap(addr_strap),
        .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .conv_done(conv_done), .volt_data(volt_data), .curr_data(curr_data),
        .status_in(status_in), .conv_req_v(conv_req_v), .conv_req_i(conv_req_i),
        .vrange_o(vrange_o), .alert_en_o(alert_en_o),
        .alert_thr_o(alert_thr_o), .ctrl_o(ctrl_o)
    );

    localparam int Q = 8;
    localparam int H = 16;
    localparam logic [7:0] AW = 8'hF4;
    localparam logic [7:0] AR = 8'hF5;

    int    total = 0, bad = 0;
    bit    done_all = 1'b0;
    string tag_q[$];
    int    exp_q[$];
    int    obs_q[$];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_val(input string tag, input int v);
        tag_q.push_back(tag);
        exp_q.push_back(v);
    endtask

    task automatic observe(input int v);
        obs_q.push_back(v);
    endtask

    task automatic chk(input string tag, input int obs, input int exp);
        expect_val(tag, exp);
        observe(obs);
    endtask

    initial begin : monitor
        forever begin
            int o, e;
            string t;
            wait (obs_q.size() > 0);
            o = obs_q.pop_front();
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL unexpected: actual=%0h expected=none", o);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (o != e) begin
                    bad++;
                    $display("FAIL %s: actual=%0h expected=%0h", t, o, e);
                end
            end
        end
    end

    task automatic bus_start;
        sda_m = 1'b1; scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_restart;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(H / 2);
        s = sda_line; tick(H / 2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, input string tag, input int exp_ack);
        logic s;
        for (int k = 7; k >= 0; k--) clk_bit(b[k], s);
        clk_bit(1'b1, s);
        expect_val(tag, exp_ack);
        observe(int'(s));
    endtask

    task automatic rbyte(input logic m_ack, input string tag, input int exp);
        logic       s;
        logic [7:0] r;
        for (int k = 7; k >= 0; k--) begin
            clk_bit(1'b1, s);
            r[k] = s;
        end
        clk_bit(~m_ack, s);
        sda_m = 1'b1;
        expect_val(tag, exp);
        observe(int'(r));
    endtask

    task automatic send_cmd(input logic [7:0] c, input string tag);
        bus_start;
        wbyte(AW, tag, 0);
        wbyte(c, tag, 0);
        bus_stop;
    endtask

    task automatic pulse_done(input logic [11:0] v, input logic [11:0] i);
        volt_data = v; curr_data = i;
        conv_done = 1'b1; tick(1);
        conv_done = 1'b0; tick(2);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done_all) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        tick(5);
        rst = 1'b0;
        tick(5);
        // R12: reset state
        chk("R12 sda", int'(sda_oe), 0);
        chk("R12 reqv", int'(conv_req_v), 0);
        chk("R12 reqi", int'(conv_req_i), 0);
        chk("R12 regs", int'({alert_en_o, alert_thr_o, ctrl_o, 7'd0, vrange_o}), 0);

        // R1: strap 10 -> E4 is foreign, F4 is ours
        bus_start; wbyte(8'hE4, "R1 foreign", 1); bus_stop;
        addr_strap = 2'b00;
        bus_start; wbyte(8'hE4, "R1 strap00", 0); bus_stop;
        addr_strap = 2'b10;

        // R9: quick command leaves everything as it was
        bus_start; wbyte(AW, "R9 ack", 0); bus_stop;
        chk("R9 state", int'({conv_req_v, conv_req_i, vrange_o, alert_en_o, ctrl_o}), 0);

        // R2: command decode incl. range
        send_cmd(8'h15, "R2");
        chk("R2 reqv", int'(conv_req_v), 1);
        chk("R2 reqi", int'(conv_req_i), 1);
        chk("R2 range", int'(vrange_o), 1);

        // R5: continuous read before first done -> zeros, acked
        bus_start; wbyte(AR, "R5 ack", 0);
        rbyte(1'b1, "R5 b0", 8'h00); rbyte(1'b1, "R5 b1", 8'h00);
        rbyte(1'b0, "R5 b2", 8'h00); bus_stop;

        // R6: both channels interleave
        pulse_done(12'hABC, 12'h123);
        bus_start; wbyte(AR, "R6 ack", 0);
        rbyte(1'b1, "R6 b0", 8'hAB); rbyte(1'b1, "R6 b1", 8'h12);
        rbyte(1'b0, "R6 b2", 8'hC3); bus_stop;

        // R3: extended registers; data with bit4 clear must not touch range
        bus_start; wbyte(AW, "R3", 0); wbyte(8'h81, "R3", 0); wbyte(8'h5C, "R3", 0); bus_stop;
        bus_start; wbyte(AW, "R3", 0); wbyte(8'h82, "R3", 0); wbyte(8'h33, "R3", 0); bus_stop;
        bus_start; wbyte(AW, "R3", 0); wbyte(8'h83, "R3", 0); wbyte(8'h00, "R3", 0); bus_stop;
        chk("R3 alen", int'(alert_en_o), 8'h5C);
        chk("R3 thr", int'(alert_thr_o), 8'h33);
        chk("R3 ctrl", int'(ctrl_o), 8'h00);
        chk("R3 range", int'(vrange_o), 1);
        bus_start; wbyte(AW, "R3", 0); wbyte(8'h83, "R3", 0); wbyte(8'h7F, "R3", 0); bus_stop;
        chk("R3 ctrl2", int'(ctrl_o), 8'h7F);

        // R4: one-shot voltage -> read refused until done
        send_cmd(8'h02, "R4");
        chk("R4 req", int'(conv_req_v), 1);
        bus_start; wbyte(AR, "R4 nack", 1); bus_stop;
        pulse_done(12'h5A7, 12'hFFF);
        chk("R4 cleared", int'(conv_req_v), 0);
        // R7: single channel two bytes, then zero padding
        bus_start; wbyte(AR, "R4 ack", 0);
        rbyte(1'b1, "R7 b0", 8'h5A); rbyte(1'b1, "R7 b1", 8'h70);
        rbyte(1'b0, "R7 pad", 8'h00); bus_stop;

        // R7: one-shot current
        send_cmd(8'h08, "R7");
        pulse_done(12'hAAA, 12'h3E1);
        bus_start; wbyte(AR, "R7 ack", 0);
        rbyte(1'b1, "R7 i0", 8'h3E); rbyte(1'b0, "R7 i1", 8'h10); bus_stop;

        // R8: status read
        send_cmd(8'h40, "R8");
        bus_start; wbyte(AR, "R8 ack", 0); rbyte(1'b0, "R8 stat", 8'h96); bus_stop;

        // R10: master NACK on first byte, slave lets go
        send_cmd(8'h05, "R10");
        pulse_done(12'h864, 12'h2F9);
        bus_start; wbyte(AR, "R10 ack", 0);
        rbyte(1'b0, "R10 b0", 8'h86);
        tick(H);
        chk("R10 released", int'(sda_oe), 0);
        scl_m = 1'b1; tick(H);
        chk("R10 released hi", int'(sda_oe), 0);
        scl_m = 1'b0; tick(Q);
        bus_stop;

        // R11: repeated START restarts payload at byte 0
        bus_start; wbyte(AR, "R11 ack", 0);
        rbyte(1'b1, "R11 b0", 8'h86); rbyte(1'b0, "R11 b1", 8'h2F);
        bus_restart; wbyte(AR, "R11 ack2", 0);
        rbyte(1'b1, "R11 again", 8'h86); rbyte(1'b1, "R11 b1b", 8'h2F);
        rbyte(1'b0, "R11 b2", 8'h49); bus_stop;

        tick(20);
        wait (obs_q.size() == 0);
        tick(2);
        done_all = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule